// File: doc/BRIEF.md
# Registered Add/Subtract Unit with Status Flags

This block adds or subtracts two 8-bit operands and reports, next to the 8-bit result, the six status conditions a small processor needs to branch on: zero, carry (borrow on subtraction), auxiliary carry across the nibble boundary, sign, signed overflow and even parity. The six flags also come out packed into a 16-bit status word with fixed bit positions, so that software reading the word after each operation finds every condition in a known place.

A caller presents the operands and the operation on a valid strobe, and the block registers them. The result and flags are computed from the registered operands and appear with a one-cycle valid pulse. They then stay put until the next strobe has passed through. Subtraction is carried out as the first operand plus the inverted second operand plus one. The raw carries are then inverted so that they read as borrows.

Top module: `afu_top`

## Requirements
- R1: With `in_op` = 0 (add) the result equals (A + B) modulo 256.
- R2: With `in_op` = 1 (subtract) the result equals (A - B) modulo 256, including A < B and both operands negative.
- R3: The zero flag is 1 exactly when all 8 result bits are 0.
- R4: On add, the carry flag is the carry out of bit 7. On subtract, it is 1 when unsigned A < B (borrow).
- R5: On add, the auxiliary flag is the carry from bit 3 into bit 4. On subtract, it is 1 when A[3:0] < B[3:0] (nibble borrow).
- R6: The sign flag equals bit 7 of the result.
- R7: The overflow flag is 1 exactly when the true signed result of the operation lies outside -128..127.
- R8: The parity flag is 1 when the result has an even number of one bits.
- R9: The status word holds overflow at bit 11, sign at bit 7, zero at bit 6, auxiliary at bit 4, parity at bit 2 and carry at bit 0. Every other bit, including the direction, interrupt and trap positions (10, 9, 8) and bits 15..12, reads 0.
- R10: An operation strobed with `in_valid` at rising edge k has its results on the outputs from edge k+1, and `out_valid` is high for exactly that one cycle. Strobes on consecutive cycles give consecutive results in order.
- R11: While no result is being delivered, the result, flags and status word hold their last values, and operand or operation changes with `in_valid` low have no effect.
- R12: A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 1 | 0 = add, 1 = subtract |
| in_a | input | W | First operand (minuend) |
| in_b | input | W | Second operand (subtrahend) |
| out_valid | output | 1 | One-cycle pulse with a new result |
| out_result | output | W | Result |
| out_zero | output | 1 | Zero flag |
| out_carry | output | 1 | Carry / borrow flag |
| out_aux | output | 1 | Nibble carry / borrow flag |
| out_sign | output | 1 | Sign flag |
| out_ovf | output | 1 | Signed overflow flag |
| out_parity | output | 1 | Even parity flag |
| out_flags | output | 16 | Packed status word |

## Verification
The bench builds the unit with its defaults, an 8-bit datapath and a 4-bit nibble boundary. These are the values at which the status word layout and the parity span are defined. At that width every corner is reachable: sums that wrap to zero, 0x7F+1 and 0x80-1 for signed overflow in both directions, negative-minus-positive cases, and nibble borrows with no full borrow. The bench also sends strobes back to back and with idle gaps full of changing operands, so that it checks the one-cycle pulse, the ordering and the holding of results.

// File: rtl/afu_pkg.sv
package afu_pkg;

  typedef enum logic {
    AFU_ADD = 1'b0,
    AFU_SUB = 1'b1
  } afu_op_e;

  localparam int FLAG_WORD_W = 16;
  localparam int POS_OVF     = 11;
  localparam int POS_SIGN    = 7;
  localparam int POS_ZERO    = 6;
  localparam int POS_AUX     = 4;
  localparam int POS_PAR     = 2;
  localparam int POS_CRY     = 0;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic aux;
    logic par;
    logic cry;
  } afu_flags_t;

endpackage

// File: rtl/afu_adder.sv
// Adder core: one shared adder for add and subtract, exposing the three
// internal carries that flag logic needs (nibble, into MSB, out of MSB).
module afu_adder #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         c_nib,
  output logic         c_msb_in,
  output logic         c_out
);
  logic [W-1:0] b_eff;
  logic [NIB:0] lo_sum;
  logic [W-1:0] low_sum;
  logic [W:0]   full_sum;

  always_comb begin
    b_eff    = sub ? ~b : b;
    lo_sum   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + (NIB+1)'(sub);
    low_sum  = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + W'(sub);
    full_sum = {1'b0, a} + {1'b0, b_eff} + (W+1)'(sub);
    sum      = full_sum[W-1:0];
    c_nib    = lo_sum[NIB];
    c_msb_in = low_sum[W-1];
    c_out    = full_sum[W];
  end
endmodule

// File: rtl/afu_flag_gen.sv
// Derives the six status conditions from the adder outputs and packs them.
module afu_flag_gen
  import afu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   sub,
  input  logic [W-1:0]           sum,
  input  logic                   c_nib,
  input  logic                   c_msb_in,
  input  logic                   c_out,
  output afu_flags_t             flags,
  output logic [FLAG_WORD_W-1:0] word
);
  localparam int PAR_BITS = 8;

  always_comb begin
    flags.zero = (sum == '0);
    flags.sign = sum[W-1];
    // Raw carries become borrows on subtraction.
    flags.cry  = c_out ^ sub;
    flags.aux  = c_nib ^ sub;
    flags.ovf  = c_msb_in ^ c_out;
    flags.par  = ~^sum[PAR_BITS-1:0];
  end

  always_comb begin
    word           = '0;
    word[POS_OVF]  = flags.ovf;
    word[POS_SIGN] = flags.sign;
    word[POS_ZERO] = flags.zero;
    word[POS_AUX]  = flags.aux;
    word[POS_PAR]  = flags.par;
    word[POS_CRY]  = flags.cry;
  end
endmodule

// File: rtl/afu_top.sv
module afu_top
  import afu_pkg::*;
#(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_op,
  input  logic [W-1:0]           in_a,
  input  logic [W-1:0]           in_b,
  output logic                   out_valid,
  output logic [W-1:0]           out_result,
  output logic                   out_zero,
  output logic                   out_carry,
  output logic                   out_aux,
  output logic                   out_sign,
  output logic                   out_ovf,
  output logic                   out_parity,
  output logic [FLAG_WORD_W-1:0] out_flags
);
  // Stage 1: operand capture
  logic         cap_vld;
  afu_op_e      cap_op;
  logic [W-1:0] cap_a, cap_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld <= 1'b0;
      cap_op  <= AFU_ADD;
      cap_a   <= '0;
      cap_b   <= '0;
    end else begin
      cap_vld <= in_valid;
      if (in_valid) begin
        cap_op <= afu_op_e'(in_op);
        cap_a  <= in_a;
        cap_b  <= in_b;
      end
    end
  end

  // Combinational datapath
  logic                   is_sub;
  logic [W-1:0]           sum;
  logic                   c_nib, c_msb_in, c_out;
  afu_flags_t             flg;
  logic [FLAG_WORD_W-1:0] word;

  assign is_sub = (cap_op == AFU_SUB);

  afu_adder #(.W(W), .NIB(NIB)) u_adder (
    .sub      (is_sub),
    .a        (cap_a),
    .b        (cap_b),
    .sum      (sum),
    .c_nib    (c_nib),
    .c_msb_in (c_msb_in),
    .c_out    (c_out)
  );

  afu_flag_gen #(.W(W)) u_flags (
    .sub      (is_sub),
    .sum      (sum),
    .c_nib    (c_nib),
    .c_msb_in (c_msb_in),
    .c_out    (c_out),
    .flags    (flg),
    .word     (word)
  );

  // Stage 2: result registers, held until the next captured operation
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b0;
      out_carry  <= 1'b0;
      out_aux    <= 1'b0;
      out_sign   <= 1'b0;
      out_ovf    <= 1'b0;
      out_parity <= 1'b0;
      out_flags  <= '0;
    end else begin
      out_valid <= cap_vld;
      if (cap_vld) begin
        out_result <= sum;
        out_zero   <= flg.zero;
        out_carry  <= flg.cry;
        out_aux    <= flg.aux;
        out_sign   <= flg.sign;
        out_ovf    <= flg.ovf;
        out_parity <= flg.par;
        out_flags  <= word;
      end
    end
  end
endmodule

// File: rtl/afu_checker.sv
module afu_checker
  import afu_pkg::*;
#(
  parameter int W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic [W-1:0]           out_result,
  input logic                   out_zero,
  input logic                   out_carry,
  input logic                   out_aux,
  input logic                   out_sign,
  input logic                   out_ovf,
  input logic                   out_parity,
  input logic [FLAG_WORD_W-1:0] out_flags
);
  assert_zero_matches_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_zero == (out_result == '0)));

  assert_sign_is_msb_R6: assert property (@(posedge clk) disable iff (rst)
    out_sign == out_result[W-1]);

  assert_parity_even_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_parity == ~^out_result[7:0]));

  assert_word_layout_R9: assert property (@(posedge clk) disable iff (rst)
    (out_flags[POS_OVF] == out_ovf) && (out_flags[POS_SIGN] == out_sign) &&
    (out_flags[POS_ZERO] == out_zero) && (out_flags[POS_AUX] == out_aux) &&
    (out_flags[POS_PAR] == out_parity) && (out_flags[POS_CRY] == out_carry));

  assert_spare_bits_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ($countones(out_flags) == $countones({out_ovf, out_sign, out_zero,
                                          out_aux, out_parity, out_carry})));

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_result) && $stable(out_flags)));
endmodule

bind afu_top afu_checker #(.W(W)) u_afu_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_zero   (out_zero),
  .out_carry  (out_carry),
  .out_aux    (out_aux),
  .out_sign   (out_sign),
  .out_ovf    (out_ovf),
  .out_parity (out_parity),
  .out_flags  (out_flags)
);

// File: tb/tb_afu_top.sv
module tb_afu_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_op = 1'b0;
  logic [7:0]  in_a = '0, in_b = '0;
  logic        out_valid, out_zero, out_carry, out_aux, out_sign, out_ovf, out_parity;
  logic [7:0]  out_result;
  logic [15:0] out_flags;

  afu_top #(.W(8), .NIB(4)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
    .out_zero(out_zero), .out_carry(out_carry), .out_aux(out_aux),
    .out_sign(out_sign), .out_ovf(out_ovf), .out_parity(out_parity),
    .out_flags(out_flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        sub;
    logic [7:0]  res;
    logic [15:0] word;
    int          due;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks = 0, n_fail = 0, cyc = 0;
  bit          mon_on = 1'b0, done = 1'b0;
  logic [7:0]  last_res = '0;
  logic [15:0] last_word = '0;
  logic [31:0] rng = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Reference model written from the requirements
  function automatic exp_t model(input logic sub, input logic [7:0] a, input logic [7:0] b);
    exp_t e;
    int sa, sb, sr;
    logic c, ac, ov, p;
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (!sub) begin
      e.res = a + b;
      c  = (int'(a) + int'(b)) > 255;
      ac = (int'(a[3:0]) + int'(b[3:0])) > 15;
      sr = sa + sb;
    end else begin
      e.res = a - b;
      c  = a < b;
      ac = a[3:0] < b[3:0];
      sr = sa - sb;
    end
    ov = (sr > 127) || (sr < -128);
    p  = ($countones(e.res) % 2) == 0;
    e.sub  = sub;
    e.word = '0;
    e.word[11] = ov;
    e.word[7]  = e.res[7];
    e.word[6]  = (e.res == 8'h00);
    e.word[4]  = ac;
    e.word[2]  = p;
    e.word[0]  = c;
    e.due = 0;
    return e;
  endfunction

  // Driver: called right after a falling edge
  task automatic drive(input logic sub, input logic [7:0] a, input logic [7:0] b);
    exp_t e;
    e = model(sub, a, b);
    e.due = cyc + 2;
    sb_q.push_back(e);
    in_valid = 1'b1; in_op = sub; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      in_op = rng[0]; in_a = rng[15:8]; in_b = rng[23:16];   // R11 noise
      @(negedge clk);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10", "unexpected out_valid", 16'h1, 16'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(cyc == e.due, "R10", "latency cycle", 16'(cyc), 16'(e.due));
          check(out_result == e.res, e.sub ? "R2" : "R1", "result", 16'(out_result), 16'(e.res));
          check(out_zero == e.word[6], "R3", "zero", 16'(out_zero), 16'(e.word[6]));
          check(out_carry == e.word[0], "R4", "carry", 16'(out_carry), 16'(e.word[0]));
          check(out_aux == e.word[4], "R5", "aux", 16'(out_aux), 16'(e.word[4]));
          check(out_sign == e.word[7], "R6", "sign", 16'(out_sign), 16'(e.word[7]));
          check(out_ovf == e.word[11], "R7", "overflow", 16'(out_ovf), 16'(e.word[11]));
          check(out_parity == e.word[2], "R8", "parity", 16'(out_parity), 16'(e.word[2]));
          check(out_flags == e.word, "R9", "flag word", out_flags, e.word);
          last_res  = e.res;
          last_word = e.word;
        end
      end else begin
        check(out_result == last_res && out_flags == last_word, "R11", "held value",
              {out_result, out_flags[11:4]}, {last_res, last_word[11:4]});
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (!done && cyc > WATCHDOG) begin
      check(1'b0, "R10", "watchdog expired", 16'(cyc), 16'(WATCHDOG));
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && out_result == 0 && out_flags == 0 &&
          {out_zero, out_carry, out_aux, out_sign, out_ovf, out_parity} == 0,
          "R12", "reset state", {out_valid, out_result, 7'(0)}, 16'h0);
    mon_on = 1'b1;

    // Worked corner cases
    drive(0, 8'd44, 8'd52);    idle(2);
    drive(0, 8'd97, 8'd48);    idle(1);
    drive(1, 8'd99, 8'd33);    idle(3);
    drive(1, 8'd33, 8'd99);    idle(1);
    drive(0, 8'hE3, 8'hE0);    idle(2);   // -29 + -32
    drive(1, 8'hD7, 8'h5F);    idle(2);   // -41 - 95
    drive(0, 8'd100, 8'd28);   idle(1);
    drive(1, 8'd27, 8'd100);   idle(1);
    drive(0, 8'h00, 8'h00);    idle(1);   // R3 zero
    drive(0, 8'hFF, 8'h01);    idle(1);   // R4 wrap to zero with carry
    drive(0, 8'h7F, 8'h01);    idle(1);   // R7 positive overflow
    drive(1, 8'h80, 8'h01);    idle(1);   // R7 negative overflow
    drive(1, 8'h10, 8'h01);    idle(1);   // R5 nibble borrow only
    drive(0, 8'h0F, 8'h01);    idle(1);   // R5 nibble carry only
    drive(1, 8'h55, 8'h55);    idle(4);   // R3 subtract to zero

    // Back-to-back strobes (R10 ordering)
    for (int i = 0; i < 60; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      begin
        exp_t e;
        e = model(rng[0], rng[15:8], rng[23:16]);
        e.due = cyc + 2;
        sb_q.push_back(e);
        in_valid = 1'b1; in_op = rng[0]; in_a = rng[15:8]; in_b = rng[23:16];
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    idle(3);

    // Random with gaps
    for (int i = 0; i < 150; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      drive(rng[1], rng[15:8], rng[31:24]);
      idle(int'(rng[5:4]));
    end

    idle(4);
    check(sb_q.size() == 0, "R10", "results outstanding", 16'(sb_q.size()), 16'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule